// File: doc/BRIEF.md
# Priority Multi-Queue Transmit Descriptor Scheduler

This block sits between a host's descriptor rings and a network transmitter. It keeps one current ring pointer for each of several transmit priority queues. When software starts transmission, it visits the queues in descending index order, from the highest queue down to queue 0. On each queue it reads descriptors one after another and collects the buffers of a packet until one carries the last-buffer flag. It then hands the packet back to software by setting the used flag in the packet's first descriptor, and moves that queue's pointer past the packet. It keeps going on the same queue until it meets a descriptor that software still leaves marked used. That ends the queue and raises a transmit-used event.

Every finished packet raises a transmit-complete event. The event goes into an unmasked status word, into a maskable global interrupt word and into a per-queue completion bit that has its own mask. A packet whose buffers add up to more than the maximum frame size is dropped. It is still handed back to software, and it raises an error event in place of completion. Dropping the transmit enable aborts a walk at once and rewinds every queue pointer to the transmit base address. The payload bytes, CRC and the line-side transmitter live elsewhere. This block only moves descriptor state.

A descriptor is two 32-bit words. Only word 1, at descriptor address + 4, is read or written here: bit 31 is the used flag, bit 30 the wrap flag, bit 15 the last-buffer flag, and bits 13:0 the buffer length in bytes.

Top module: `txq_sched`

## Requirements
- R1: After reset, mem_req and busy are low and tx_stat, int_glb and int_q are all zero.
- R2: A tx_start pulse while tx_enable is low is ignored: no memory request is issued and busy stays low.
- R3: After a start, queues are visited from index NQ-1 down to 0. Each visit begins with a read of word 1 at that queue's current pointer + 4.
- R4: Within a queue, descriptor word 1 is read at successive descriptors until one has bit 15 (last) set. The block then performs one write to the packet's first descriptor word 1, with bit 31 set and all other bits as read. No other descriptor is written.
- R5: After a packet, the queue pointer becomes the last descriptor's address + 8. If that descriptor has bit 30 (wrap) set, it becomes the transmit base instead. Non-last descriptors follow the same rule when the block steps to the next buffer.
- R6: A descriptor read with bit 31 (used) set ends the visit of that queue and sets status bit 1 (used). That descriptor is not written.
- R7: A transmitted packet sets tx_stat bit 0 (complete). It also sets int_glb bit 0 unless glb_mask bit 0 is set, and int_q bit q unless q_mask bit q is set. Used and error events likewise reach int_glb bits 1 and 2 unless masked.
- R8: A packet whose length fields sum to more than MAXB bytes is dropped. It sets status bit 2 (error) and not bit 0, and it is still consumed (first descriptor marked used, pointer advanced). A sum of exactly MAXB is transmitted normally.
- R9: A falling edge of tx_enable rewinds every queue pointer to the transmit base. A walk in progress stops: mem_req and busy are low from the next cycle on.
- R10: A configuration write to queue 0 sets both the transmit base and queue 0's pointer. A write to queue q > 0 sets only that queue's pointer.
- R11: A status_clr pulse clears tx_stat, int_glb and int_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmit enable; its falling edge rewinds all queues |
| tx_start | input | 1 | Start pulse, honoured only while enabled and idle |
| cfg_wr | input | 1 | Queue pointer configuration write strobe |
| cfg_q | input | $clog2(NQ) | Queue index for the configuration write |
| cfg_ptr | input | AW | Pointer value (queue 0: also transmit base) |
| mem_req | output | 1 | Descriptor memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of descriptor word 1 |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| glb_mask | input | 3 | Global interrupt mask (bit0 complete, bit1 used, bit2 error) |
| q_mask | input | NQ | Per-queue completion interrupt mask |
| status_clr | input | 1 | Clears all status words |
| busy | output | 1 | A walk is in progress |
| tx_stat | output | 3 | Unmasked sticky status (bit0 complete, bit1 used, bit2 error) |
| int_glb | output | 3 | Masked sticky global interrupt status |
| int_q | output | NQ | Masked sticky per-queue completion status |

## Verification
The bench logs every descriptor read address at the memory port. That log shows a scheduler that walked the queues in ascending order, or that restarted a queue from its base rather than from its advanced pointer. Marking the last descriptor instead of the first is caught by the descriptor words left in memory. Ignoring the wrap flag shows up as a read past the ring end. The drop boundary is exercised just over and exactly at 2048 bytes, so an off-by-one comparison either drops a legal frame or sends an oversized one. Disable is tested both between walks and in mid-walk: a design that failed to rewind, or that kept issuing requests, produces reads at stale addresses or after the abort.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

  // Descriptor word-1 field positions
  localparam int DW        = 32;
  localparam int DESC_USED = 31;
  localparam int DESC_WRAP = 30;
  localparam int DESC_LAST = 15;
  localparam int LENW      = 14;

  // Status bit positions
  localparam int ST_CMPL = 0;
  localparam int ST_USED = 1;
  localparam int ST_ERR  = 2;
  localparam int STW     = 3;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOAD  = 3'd1,
    S_RD    = 3'd2,
    S_WR    = 3'd3,
    S_NEXTQ = 3'd4
  } walk_state_t;

endpackage

// File: rtl/txq_ptr_bank.sv
module txq_ptr_bank #(
  parameter  int NQ = 4,
  parameter  int AW = 32,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             cfg_wr,
  input  logic [QW-1:0]    cfg_q,
  input  logic [AW-1:0]    cfg_ptr,
  input  logic             adv_en,
  input  logic [QW-1:0]    adv_q,
  input  logic [AW-1:0]    adv_ptr,
  output logic [NQ*AW-1:0] ptr_flat,
  output logic [AW-1:0]    base
);

  logic          en_q;
  logic          rewind;
  logic [AW-1:0] base_q, base_n;

  assign rewind = en_q & ~tx_enable;
  assign base   = base_q;

  always_comb begin
    base_n = base_q;
    if (cfg_wr && (cfg_q == '0)) base_n = cfg_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
    end else begin
      en_q   <= tx_enable;
      base_q <= base_n;
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [AW-1:0] p_q, p_n;
    logic          p_en;

    always_comb begin
      p_n  = p_q;
      p_en = 1'b0;
      if (rewind) begin
        p_n  = base_q;
        p_en = 1'b1;
      end else if (adv_en && (adv_q == QW'(g))) begin
        p_n  = adv_ptr;
        p_en = 1'b1;
      end else if (cfg_wr && (cfg_q == QW'(g))) begin
        p_n  = cfg_ptr;
        p_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    p_q <= '0;
      else if (p_en) p_q <= p_n;
    end

    assign ptr_flat[g*AW +: AW] = p_q;
  end

  AST_ADV_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |-> tx_enable); // R9

endmodule

// File: rtl/txq_walker.sv
module txq_walker
  import txq_sched_pkg::*;
#(
  parameter  int NQ   = 4,
  parameter  int AW   = 32,
  parameter  int MAXB = 2048,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int TW   = LENW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             tx_start,
  input  logic [NQ*AW-1:0] ptr_flat,
  input  logic [AW-1:0]    base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             adv_en,
  output logic [QW-1:0]    adv_q,
  output logic [AW-1:0]    adv_ptr,
  output logic             ev_cmpl,
  output logic             ev_used,
  output logic             ev_err,
  output logic [QW-1:0]    ev_q,
  output logic             busy
);

  walk_state_t   st, st_n;
  logic [QW-1:0] q, q_n;
  logic [AW-1:0] cur, cur_n;
  logic [AW-1:0] first, first_n;
  logic [AW-1:0] nxt, nxt_n;
  logic [DW-1:0] w1, w1_n;
  logic [TW-1:0] tot, tot_n;
  logic          drop, drop_n;
  logic          fresh, fresh_n;

  logic [AW-1:0] ptr_sel;
  logic [AW-1:0] step_tgt;
  logic [TW-1:0] sum;

  assign ptr_sel  = ptr_flat[int'(q)*AW +: AW];
  assign step_tgt = mem_rdata[DESC_WRAP] ? base : (cur + AW'(8));
  assign sum      = tot + TW'(mem_rdata[LENW-1:0]);

  always_comb begin
    st_n    = st;
    q_n     = q;
    cur_n   = cur;
    first_n = first;
    nxt_n   = nxt;
    w1_n    = w1;
    tot_n   = tot;
    drop_n  = drop;
    fresh_n = fresh;
    adv_en  = 1'b0;
    ev_cmpl = 1'b0;
    ev_used = 1'b0;
    ev_err  = 1'b0;
    if ((st != S_IDLE) && !tx_enable) begin
      st_n = S_IDLE;
    end else begin
      case (st)
        S_IDLE: begin
          if (tx_start && tx_enable) begin
            q_n  = QW'(NQ - 1);
            st_n = S_LOAD;
          end
        end
        S_LOAD: begin
          cur_n   = ptr_sel;
          first_n = ptr_sel;
          tot_n   = '0;
          drop_n  = 1'b0;
          fresh_n = 1'b1;
          st_n    = S_RD;
        end
        S_RD: begin
          if (mem_ack) begin
            if (mem_rdata[DESC_USED]) begin
              ev_used = 1'b1;
              st_n    = S_NEXTQ;
            end else begin
              if (fresh) w1_n = mem_rdata;
              fresh_n = 1'b0;
              if (sum > TW'(MAXB)) begin
                drop_n = 1'b1;
                tot_n  = TW'(MAXB + 1);
              end else begin
                tot_n = sum;
              end
              if (mem_rdata[DESC_LAST]) begin
                nxt_n = step_tgt;
                st_n  = S_WR;
              end else begin
                cur_n = step_tgt;
              end
            end
          end
        end
        S_WR: begin
          if (mem_ack) begin
            adv_en  = 1'b1;
            ev_cmpl = ~drop;
            ev_err  = drop;
            st_n    = S_LOAD;
          end
        end
        S_NEXTQ: begin
          if (q == '0) begin
            st_n = S_IDLE;
          end else begin
            q_n  = q - 1'b1;
            st_n = S_LOAD;
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      q     <= '0;
      cur   <= '0;
      first <= '0;
      nxt   <= '0;
      w1    <= '0;
      tot   <= '0;
      drop  <= 1'b0;
      fresh <= 1'b0;
    end else begin
      st    <= st_n;
      q     <= q_n;
      cur   <= cur_n;
      first <= first_n;
      nxt   <= nxt_n;
      w1    <= w1_n;
      tot   <= tot_n;
      drop  <= drop_n;
      fresh <= fresh_n;
    end
  end

  always_comb begin
    mem_req   = (st == S_RD) || (st == S_WR);
    mem_we    = (st == S_WR);
    mem_addr  = ((st == S_WR) ? first : cur) + AW'(4);
    mem_wdata = w1 | (DW'(1) << DESC_USED);
  end

  assign adv_q   = q;
  assign adv_ptr = nxt;
  assign ev_q    = q;
  assign busy    = (st != S_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && tx_enable) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
  AST_WR_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[DESC_USED]); // R4
  AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> (!mem_req && !busy)); // R9
  AST_Q_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (q != $past(q))) |-> (q == QW'($past(q) - 1'b1))); // R3
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_enable)); // R2

endmodule

// File: rtl/txq_irq_stat.sv
module txq_irq_stat
  import txq_sched_pkg::*;
#(
  parameter  int NQ = 4,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_cmpl,
  input  logic           ev_used,
  input  logic           ev_err,
  input  logic [QW-1:0]  ev_q,
  input  logic [STW-1:0] glb_mask,
  input  logic [NQ-1:0]  q_mask,
  input  logic           status_clr,
  output logic [STW-1:0] tx_stat,
  output logic [STW-1:0] int_glb,
  output logic [NQ-1:0]  int_q
);

  logic [STW-1:0] ev;
  logic [STW-1:0] stat_n, glb_n;
  logic [NQ-1:0]  q_n, q_hit;

  always_comb begin
    ev          = '0;
    ev[ST_CMPL] = ev_cmpl;
    ev[ST_USED] = ev_used;
    ev[ST_ERR]  = ev_err;
    q_hit       = ev_cmpl ? (NQ'(1) << ev_q) : '0;
    stat_n      = (status_clr ? '0 : tx_stat) | ev;
    glb_n       = (status_clr ? '0 : int_glb) | (ev & ~glb_mask);
    q_n         = (status_clr ? '0 : int_q) | (q_hit & ~q_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_stat <= '0;
      int_glb <= '0;
      int_q   <= '0;
    end else begin
      tx_stat <= stat_n;
      int_glb <= glb_n;
      int_q   <= q_n;
    end
  end

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_cmpl, ev_used, ev_err})); // R8
  AST_GLB_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_glb[ST_CMPL]) |-> !$past(glb_mask[ST_CMPL])); // R7
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !ev_cmpl && !ev_used && !ev_err) |=> ((tx_stat == '0) && (int_q == '0))); // R11

endmodule

// File: rtl/txq_sched.sv
module txq_sched
  import txq_sched_pkg::*;
#(
  parameter  int NQ   = 4,
  parameter  int AW   = 32,
  parameter  int MAXB = 2048,
  localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_enable,
  input  logic          tx_start,
  input  logic          cfg_wr,
  input  logic [QW-1:0] cfg_q,
  input  logic [AW-1:0] cfg_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic [2:0]    glb_mask,
  input  logic [NQ-1:0] q_mask,
  input  logic          status_clr,
  output logic          busy,
  output logic [2:0]    tx_stat,
  output logic [2:0]    int_glb,
  output logic [NQ-1:0] int_q
);

  logic [NQ*AW-1:0] ptr_flat;
  logic [AW-1:0]    base;
  logic             adv_en;
  logic [QW-1:0]    adv_q;
  logic [AW-1:0]    adv_ptr;
  logic             ev_cmpl, ev_used, ev_err;
  logic [QW-1:0]    ev_q;

  txq_ptr_bank #(.NQ(NQ), .AW(AW)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .cfg_wr    (cfg_wr),
    .cfg_q     (cfg_q),
    .cfg_ptr   (cfg_ptr),
    .adv_en    (adv_en),
    .adv_q     (adv_q),
    .adv_ptr   (adv_ptr),
    .ptr_flat  (ptr_flat),
    .base      (base)
  );

  txq_walker #(.NQ(NQ), .AW(AW), .MAXB(MAXB)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_enable (tx_enable),
    .tx_start  (tx_start),
    .ptr_flat  (ptr_flat),
    .base      (base),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .adv_en    (adv_en),
    .adv_q     (adv_q),
    .adv_ptr   (adv_ptr),
    .ev_cmpl   (ev_cmpl),
    .ev_used   (ev_used),
    .ev_err    (ev_err),
    .ev_q      (ev_q),
    .busy      (busy)
  );

  txq_irq_stat #(.NQ(NQ)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_cmpl    (ev_cmpl),
    .ev_used    (ev_used),
    .ev_err     (ev_err),
    .ev_q       (ev_q),
    .glb_mask   (glb_mask),
    .q_mask     (q_mask),
    .status_clr (status_clr),
    .tx_stat    (tx_stat),
    .int_glb    (int_glb),
    .int_q      (int_q)
  );

endmodule

// File: tb/txq_sched_tb_top.sv
module txq_sched_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NQ   = 4;
  localparam int AW   = 32;
  localparam int MEMW = 1024;
  localparam int LOGN = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_enable = 1'b0;
  logic          tx_start = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_q = '0;
  logic [AW-1:0] cfg_ptr = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack;
  logic [31:0]   mem_rdata;
  logic [2:0]    glb_mask = '0;
  logic [NQ-1:0] q_mask = '0;
  logic          status_clr = 1'b0;
  logic          busy;
  logic [2:0]    tx_stat, int_glb;
  logic [NQ-1:0] int_q;

  logic [31:0]   mem [MEMW];
  logic [AW-1:0] rd_log [LOGN];
  int            rd_n = 0;
  logic          fill_go = 1'b0;
  logic          poke_en = 1'b0;
  int            poke_idx = 0;
  logic [31:0]   poke_dat = '0;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txq_sched #(.NQ(NQ), .AW(AW), .MAXB(2048)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_start(tx_start),
    .cfg_wr(cfg_wr), .cfg_q(cfg_q), .cfg_ptr(cfg_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .glb_mask(glb_mask), .q_mask(q_mask),
    .status_clr(status_clr), .busy(busy), .tx_stat(tx_stat), .int_glb(int_glb), .int_q(int_q)
  );

  // Descriptor memory model: acknowledges one cycle after a request, logs reads
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
    end else begin
      if (fill_go) begin
        for (int i = 0; i < MEMW; i++) mem[i] <= 32'h8000_0000;
      end else if (poke_en) begin
        mem[poke_idx] <= poke_dat;
      end
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_we) begin
          mem[mem_addr[11:2]] <= mem_wdata;
        end else begin
          rd_log[rd_n % LOGN] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic poke(int byte_addr, logic [31:0] val);
    @(negedge clk);
    poke_en  = 1'b1;
    poke_idx = byte_addr / 4;
    poke_dat = val;
    @(negedge clk);
    poke_en  = 1'b0;
  endtask

  task automatic cfg(int qi, logic [AW-1:0] p);
    @(negedge clk);
    cfg_wr  = 1'b1;
    cfg_q   = 2'(qi);
    cfg_ptr = p;
    @(negedge clk);
    cfg_wr  = 1'b0;
  endtask

  task automatic clr_status();
    @(negedge clk);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
  endtask

  task automatic run_walk(string req);
    int n;
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    n = 0;
    while (busy && n < 500) begin
      @(negedge clk);
      n++;
    end
    check(req, 32'(busy), 32'd0);
  endtask

  task automatic check_rd(string req, int idx, logic [31:0] exp);
    check(req, rd_log[idx % LOGN], exp);
  endtask

  task automatic t_reset();
    check("R1 mem_req", 32'(mem_req), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 status", {21'd0, tx_stat, int_glb, int_q}, 32'd0);
  endtask

  task automatic t_start_disabled();
    int n0 = rd_n;
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    repeat (5) @(negedge clk);
    check("R2 busy", 32'(busy), 32'd0);
    check("R2 reads", 32'(rd_n - n0), 32'd0);
  endtask

  task automatic t_basic();
    int n0;
    poke(32'h004, 32'h0000_0064);
    poke(32'h00C, 32'h0000_8032);
    n0 = rd_n;
    run_walk("R3 walk ends");
    check("R3 read count", 32'(rd_n - n0), 32'd6);
    check_rd("R3 q3 first", n0 + 0, 32'h304);
    check_rd("R3 q2 second", n0 + 1, 32'h204);
    check_rd("R3 q1 third", n0 + 2, 32'h104);
    check_rd("R4 q0 buf0", n0 + 3, 32'h004);
    check_rd("R4 q0 buf1", n0 + 4, 32'h00C);
    check_rd("R6 q0 used stop", n0 + 5, 32'h014);
    check("R4 first marked used", mem[1], 32'h8000_0064);
    check("R4 last untouched", mem[3], 32'h0000_8032);
    check("R7 tx_stat", 32'(tx_stat), 32'b011);
    check("R7 int_glb", 32'(int_glb), 32'b011);
    check("R7 int_q", 32'(int_q), 32'b0001);
    clr_status();
    check("R11 cleared", {21'd0, tx_stat, int_glb, int_q}, 32'd0);
  endtask

  task automatic t_advance();
    int n0;
    poke(32'h014, 32'h0000_800A);
    n0 = rd_n;
    run_walk("R5 walk ends");
    check("R5 read count", 32'(rd_n - n0), 32'd5);
    check_rd("R5 q0 resumes after packet", n0 + 3, 32'h014);
    check_rd("R5 q0 next slot", n0 + 4, 32'h01C);
    check("R5 marked", mem[5], 32'h8000_800A);
    clr_status();
  endtask

  task automatic t_wrap();
    int n0;
    poke(32'h01C, 32'h4000_8008);
    n0 = rd_n;
    run_walk("R5 wrap walk ends");
    check_rd("R5 wrap packet", n0 + 3, 32'h01C);
    check_rd("R5 wrapped to base", n0 + 4, 32'h004);
    check("R5 wrap desc marked", mem[7], 32'hC000_8008);
    clr_status();
  endtask

  task automatic t_masks();
    poke(32'h104, 32'h0000_8014);
    glb_mask = 3'b001;
    q_mask   = 4'b0010;
    run_walk("R7 mask walk ends");
    check("R7 unmasked stat", 32'(tx_stat), 32'b011);
    check("R7 glb masked", 32'(int_glb), 32'b010);
    check("R7 q masked", 32'(int_q), 32'd0);
    check("R4 q1 marked", mem[65], 32'h8000_8014);
    glb_mask = '0;
    q_mask   = '0;
    clr_status();
  endtask

  task automatic t_overflow();
    poke(32'h204, 32'h0000_07D0);
    poke(32'h20C, 32'h0000_8064);
    run_walk("R8 over walk ends");
    check("R8 drop status", 32'(tx_stat), 32'b110);
    check("R8 drop int_q", 32'(int_q), 32'd0);
    check("R8 dropped consumed", mem[129], 32'h8000_07D0);
    clr_status();
    poke(32'h214, 32'h0000_8800);
    run_walk("R8 exact walk ends");
    check("R8 exact sent", 32'(tx_stat), 32'b011);
    check("R8 exact int_q", 32'(int_q), 32'b0100);
    check("R8 exact marked", mem[133], 32'h8000_8800);
    clr_status();
  endtask

  task automatic t_rewind();
    int n0;
    @(negedge clk);
    tx_enable = 1'b0;
    repeat (2) @(negedge clk);
    tx_enable = 1'b1;
    n0 = rd_n;
    run_walk("R9 rewind walk ends");
    check("R9 read count", 32'(rd_n - n0), 32'd4);
    for (int i = 0; i < 4; i++) check_rd("R9 rewound to base", n0 + i, 32'h004);
    clr_status();
  endtask

  task automatic t_abort();
    int n0, n1;
    cfg(1, 32'h100);
    cfg(2, 32'h200);
    cfg(3, 32'h300);
    for (int i = 0; i < 4; i++) poke(32'h304 + 8 * i, 32'h0000_000A);
    n0 = rd_n;
    @(negedge clk);
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    repeat (4) @(negedge clk);
    tx_enable = 1'b0;
    @(negedge clk);
    check("R9 abort busy", 32'(busy), 32'd0);
    check("R9 abort req", 32'(mem_req), 32'd0);
    n1 = rd_n;
    repeat (10) @(negedge clk);
    check("R9 no reads after abort", 32'(rd_n - n1), 32'd0);
    check_rd("R10 q3 reprogrammed", n0, 32'h304);
    check("R9 abort no write", mem[193], 32'h0000_000A);
    check("R9 abort no status", 32'(tx_stat), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    @(negedge clk);
    fill_go = 1'b1;
    @(negedge clk);
    fill_go = 1'b0;
    cfg(0, 32'h000);
    cfg(1, 32'h100);
    cfg(2, 32'h200);
    cfg(3, 32'h300);
    t_start_disabled();
    @(negedge clk);
    tx_enable = 1'b1;
    t_basic();
    t_advance();
    t_wrap();
    t_masks();
    t_overflow();
    t_rewind();
    t_abort();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule